// File: doc/BRIEF.md
# Four-Lane SD Card Block Write Engine

This block moves one or more 512-byte data blocks from a word-wide payload stream onto a four-bit card data bus. For every block it drives all four lanes high for one cycle and then sends a zero start nibble. After that come 1024 payload nibbles, the 64-bit lane CRC supplied by the caller for that block, and a closing all-ones nibble. It then releases the lanes and reads the card's CRC status token serially on lane 0.

The token is decoded on the spot. An accepted block raises the done count and leads straight into the next block. Any other code ends the transfer with an error status. A watchdog limits the whole transfer to `TIMEOUT_CYC` cycles, which is about one second at the default setting. The block does not compute the CRC and does not wait for the card's busy signal after the token.

The engine moves one nibble per clock. `bus_clk_en_o` tells the pin-side clock generator whether a bus clock edge belongs to the current cycle. When the payload stream runs dry, that enable stays low, so the frame pauses and no filler nibble goes out.

Top module: `sd_wr_engine`

## Requirements
- R1: After reset `busy_o`, `dat_oe_o`, `data_ready_o` and `bus_clk_en_o` are 0, and `done_cnt_o` and `status_o` are 0.
- R2: A `start_i` pulse while idle with a nonzero `blk_cnt_i` starts a transfer. From the next cycle on, each block opens with one cycle of lanes 4'hF, then one cycle of 4'h0, with `dat_oe_o` high in both.
- R3: Each block then carries 1024 payload nibbles. Every accepted word is sent from bits [31:28] down to bits [3:0]. `data_ready_o` is high only in the payload phase, at a word boundary. A word is taken when `data_valid_i` and `data_ready_o` are both high, and its first nibble goes out in that same cycle.
- R4: When a payload nibble is due and `data_valid_i` is low, `bus_clk_en_o` is 0 and the frame does not advance. In every other driving or token-capture cycle, `bus_clk_en_o` is 1.
- R5: `crc_i` is latched in the all-ones cycle that opens the block. It is sent as 16 nibbles, bits [63:60] first, and is followed by one 4'hF nibble.
- R6: After the closing nibble, `dat_oe_o` goes low and `dat0_i` is sampled for 32 cycles. The first sample becomes bit 31 of the token word.
- R7: The token code is the three bits below the highest 0 bit of the token word, taken most significant first. Positions below bit 0 read as 0. Code 3'b010 means accepted. 3'b101 gives `status_o`=1 (CRC error) and 3'b110 gives 2 (write error). Any other code, or a token with no 0 bit, gives 3 (write failure).
- R8: A non-accepted token ends the transfer in the cycle after the decode cycle. `busy_o` and `dat_oe_o` then fall, and `done_cnt_o` is unchanged.
- R9: An accepted token raises `done_cnt_o` by one. When the count then equals the requested count, the transfer ends with `status_o`=0. Otherwise the next block opens in the next cycle.
- R10: A transfer still busy `TIMEOUT_CYC` cycles after its start stops with `status_o`=4 and the lanes released.
- R11: `start_i` is ignored while busy. A start with `blk_cnt_i`=0 leaves the block idle with `done_cnt_o`=0 and `status_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus nibble per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transfer when idle |
| blk_cnt_i | input | BLK_W | Number of blocks to send, sampled at start |
| data_i | input | WORD_W | Payload word |
| data_valid_i | input | 1 | Payload word valid |
| data_ready_o | output | 1 | Engine takes a word this cycle if valid |
| crc_i | input | 16*LANES | Lane CRC for the block about to open |
| dat_o | output | LANES | Lane drive value |
| dat_oe_o | output | 1 | Lane output enable |
| bus_clk_en_o | output | 1 | Bus clock edge belongs to this cycle |
| dat0_i | input | 1 | Lane 0 input for the status token |
| busy_o | output | 1 | Transfer in progress |
| done_cnt_o | output | BLK_W | Blocks accepted in this transfer |
| status_o | output | 3 | 0 ok, 1 CRC error, 2 write error, 3 write failure, 4 timeout |

## Verification
If the nibble position inside the payload phase is wrong, the very next `bus_clk_en_o` cycle puts a wrong nibble on `dat_o`. The same fault makes the CRC, the closing nibble or the token window arrive one or more cycles early or late. A bad word-hold count shows up at once as `data_ready_o` rising off a word boundary, or as a stall while a word is still held. A wrong token decode or block counter is visible one cycle after the decode cycle, through `busy_o`, `done_cnt_o` and `status_o`.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_START, S_DATA, S_CRC, S_END, S_TOKEN, S_DECODE
  } phase_e;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_CRC_ERR = 3'd1,
    ST_WR_ERR  = 3'd2,
    ST_WR_FAIL = 3'd3,
    ST_TIMEOUT = 3'd4
  } wr_status_e;

  localparam logic [2:0] TOK_ACCEPT = 3'b010;
  localparam logic [2:0] TOK_CRC    = 3'b101;
  localparam logic [2:0] TOK_WRERR  = 3'b110;
endpackage

// File: rtl/sdw_payload_shift.sv
module sdw_payload_shift #(
  parameter int WORD_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              fire_o,
  output logic [NIB_W-1:0]  nib_o
);
  localparam int NIBS = WORD_W / NIB_W;
  localparam int RW   = $clog2(NIBS + 1);

  logic [WORD_W-1:0] sh_q;
  logic [RW-1:0]     rem_q;
  logic              held;

  assign held    = (rem_q != '0);
  assign ready_o = active_i && !held;
  assign fire_o  = active_i && (held || valid_i);
  // first nibble of a fresh word passes straight through
  assign nib_o   = held ? sh_q[WORD_W-1 -: NIB_W] : data_i[WORD_W-1 -: NIB_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (!active_i) begin
      rem_q <= '0;
    end else if (held) begin
      sh_q  <= sh_q << NIB_W;
      rem_q <= rem_q - 1'b1;
    end else if (valid_i) begin
      sh_q  <= data_i << NIB_W;
      rem_q <= RW'(NIBS - 1);
    end
  end
endmodule

// File: rtl/sdw_token_rx.sv
module sdw_token_rx #(
  parameter int TOK_BITS = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shift_i,
  input  logic       bit_i,
  output logic [2:0] code_o,
  output logic       found_o
);
  localparam int PW = $clog2(TOK_BITS);

  logic [TOK_BITS-1:0] tok_q;
  logic [TOK_BITS+2:0] ext;
  logic [PW-1:0]       pos;
  logic                found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tok_q <= '1;
    else if (shift_i) tok_q <= {tok_q[TOK_BITS-2:0], bit_i};
  end

  // leading-one skip: locate the start bit from the top
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = 0; i < TOK_BITS; i++) begin
      if (!found && !tok_q[TOK_BITS-1-i]) begin
        found = 1'b1;
        pos   = PW'(TOK_BITS - 1 - i);
      end
    end
  end

  assign ext     = {tok_q, 3'b000};
  assign code_o  = ext[pos +: 3];
  assign found_o = found;
endmodule

// File: rtl/sdw_timeout.sv
module sdw_timeout #(
  parameter int LIMIT = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sd_wr_engine.sv
module sd_wr_engine
  import sdw_pkg::*;
#(
  parameter int WORDS_PER_BLK = 128,
  parameter int WORD_W        = 32,
  parameter int LANES         = 4,
  parameter int TOK_BITS      = 32,
  parameter int BLK_W         = 9,
  parameter int TIMEOUT_CYC   = 100_000_000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [BLK_W-1:0]      blk_cnt_i,
  input  logic [WORD_W-1:0]     data_i,
  input  logic                  data_valid_i,
  output logic                  data_ready_o,
  input  logic [16*LANES-1:0]   crc_i,
  output logic [LANES-1:0]      dat_o,
  output logic                  dat_oe_o,
  output logic                  bus_clk_en_o,
  input  logic                  dat0_i,
  output logic                  busy_o,
  output logic [BLK_W-1:0]      done_cnt_o,
  output logic [2:0]            status_o
);
  localparam int CRC_W    = 16 * LANES;
  localparam int CRC_NIBS = 16;
  localparam int NIB_BLK  = WORDS_PER_BLK * WORD_W / LANES;
  localparam int CNT_MAX  = (NIB_BLK > TOK_BITS) ? NIB_BLK : TOK_BITS;
  localparam int CW       = $clog2(CNT_MAX);

  phase_e           phase_q;
  logic [CW-1:0]    cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic [BLK_W-1:0] blk_q, done_q, done_nx;
  wr_status_e       status_q;

  logic             pay_fire, pay_ready;
  logic [LANES-1:0] pay_nib;
  logic [2:0]       tok_code;
  logic             tok_found, expire, busy;

  assign busy    = (phase_q != S_IDLE);
  assign done_nx = done_q + 1'b1;

  sdw_payload_shift #(.WORD_W(WORD_W), .NIB_W(LANES)) u_pay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (phase_q == S_DATA),
    .data_i   (data_i),
    .valid_i  (data_valid_i),
    .ready_o  (pay_ready),
    .fire_o   (pay_fire),
    .nib_o    (pay_nib)
  );

  sdw_token_rx #(.TOK_BITS(TOK_BITS)) u_tok (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (phase_q == S_TOKEN),
    .bit_i   (dat0_i),
    .code_o  (tok_code),
    .found_o (tok_found)
  );

  sdw_timeout #(.LIMIT(TIMEOUT_CYC)) u_to (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!busy && start_i),
    .run_i    (busy),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= S_IDLE;
      cnt_q    <= '0;
      crc_q    <= '0;
      blk_q    <= '0;
      done_q   <= '0;
      status_q <= ST_OK;
    end else if (expire) begin
      phase_q  <= S_IDLE;
      status_q <= ST_TIMEOUT;
    end else begin
      unique case (phase_q)
        S_IDLE: if (start_i) begin
          blk_q    <= blk_cnt_i;
          done_q   <= '0;
          status_q <= ST_OK;
          cnt_q    <= '0;
          if (blk_cnt_i != '0) phase_q <= S_PRE;
        end
        S_PRE: begin
          crc_q   <= crc_i;
          phase_q <= S_START;
        end
        S_START: begin
          cnt_q   <= '0;
          phase_q <= S_DATA;
        end
        S_DATA: if (pay_fire) begin
          if (cnt_q == CW'(NIB_BLK - 1)) begin
            cnt_q   <= '0;
            phase_q <= S_CRC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_CRC: begin
          crc_q <= crc_q << LANES;
          if (cnt_q == CW'(CRC_NIBS - 1)) begin
            cnt_q   <= '0;
            phase_q <= S_END;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_END: begin
          cnt_q   <= '0;
          phase_q <= S_TOKEN;
        end
        S_TOKEN: begin
          if (cnt_q == CW'(TOK_BITS - 1)) begin
            cnt_q   <= '0;
            phase_q <= S_DECODE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DECODE: begin
          if (tok_found && tok_code == TOK_ACCEPT) begin
            done_q  <= done_nx;
            phase_q <= (done_nx == blk_q) ? S_IDLE : S_PRE;
          end else begin
            phase_q <= S_IDLE;
            if (tok_found && tok_code == TOK_CRC)        status_q <= ST_CRC_ERR;
            else if (tok_found && tok_code == TOK_WRERR) status_q <= ST_WR_ERR;
            else                                         status_q <= ST_WR_FAIL;
          end
        end
        default: phase_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dat_o        = '0;
    dat_oe_o     = 1'b0;
    bus_clk_en_o = 1'b0;
    unique case (phase_q)
      S_PRE, S_END: begin
        dat_o        = '1;
        dat_oe_o     = 1'b1;
        bus_clk_en_o = 1'b1;
      end
      S_START: begin
        dat_oe_o     = 1'b1;
        bus_clk_en_o = 1'b1;
      end
      S_DATA: begin
        dat_o        = pay_nib;
        dat_oe_o     = 1'b1;
        bus_clk_en_o = pay_fire;
      end
      S_CRC: begin
        dat_o        = crc_q[CRC_W-1 -: LANES];
        dat_oe_o     = 1'b1;
        bus_clk_en_o = 1'b1;
      end
      S_TOKEN: bus_clk_en_o = 1'b1;
      default: ;
    endcase
  end

  assign data_ready_o = pay_ready;
  assign busy_o       = busy;
  assign done_cnt_o   = done_q;
  assign status_o     = status_q;
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker #(
  parameter int BLK_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             dat_oe_o,
  input logic             data_ready_o,
  input logic             data_valid_i,
  input logic             bus_clk_en_o,
  input logic [BLK_W-1:0] done_cnt_o,
  input logic [2:0]       status_o,
  input logic [BLK_W-1:0] blk_q
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!dat_oe_o && !data_ready_o && !bus_clk_en_o));

  a_r3_ready_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> (dat_oe_o && busy_o));

  a_r4_stall_only_when_starved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ready_o && !data_valid_i) |-> !bus_clk_en_o);

  a_r9_done_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      ((done_cnt_o == $past(done_cnt_o)) || (done_cnt_o == $past(done_cnt_o) + 1'b1)));

  a_r9_done_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_cnt_o <= blk_q);

  a_r8_release_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !dat_oe_o);

  a_r7_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o <= 3'd4);
endmodule

bind sd_wr_engine sdw_checker #(.BLK_W(BLK_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .dat_oe_o     (dat_oe_o),
  .data_ready_o (data_ready_o),
  .data_valid_i (data_valid_i),
  .bus_clk_en_o (bus_clk_en_o),
  .done_cnt_o   (done_cnt_o),
  .status_o     (status_o),
  .blk_q        (blk_q)
);

// File: tb/sd_wr_engine_test.sv
module sd_wr_engine_test;
  localparam int TO    = 6000;
  localparam int NIB   = 1024;
  localparam int BLK_W = 9;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [BLK_W-1:0] blk_cnt_i = '0;
  logic [31:0]      data_i = '0;
  logic             data_valid_i = 1'b0;
  logic             data_ready_o;
  logic [63:0]      crc_i = '0;
  logic [3:0]       dat_o;
  logic             dat_oe_o, bus_clk_en_o;
  logic             dat0_i = 1'b1;
  logic             busy_o;
  logic [BLK_W-1:0] done_cnt_o;
  logic [2:0]       status_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] salt;

  always #5 clk = ~clk;

  sd_wr_engine #(.BLK_W(BLK_W), .TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .blk_cnt_i(blk_cnt_i),
    .data_i(data_i), .data_valid_i(data_valid_i), .data_ready_o(data_ready_o),
    .crc_i(crc_i), .dat_o(dat_o), .dat_oe_o(dat_oe_o), .bus_clk_en_o(bus_clk_en_o),
    .dat0_i(dat0_i), .busy_o(busy_o), .done_cnt_o(done_cnt_o), .status_o(status_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pay_word(int b, int i);
    return (i * 32'h9E3779B1) ^ (b * 32'h7F4A7C15) ^ salt;
  endfunction

  function automatic logic [3:0] pay_nib(int b, int k);
    logic [31:0] w = pay_word(b, k / 8);
    return w[31 - 4 * (k % 8) -: 4];
  endfunction

  function automatic logic [63:0] blk_crc(int b);
    return {pay_word(b, 501), pay_word(b, 777)} ^ 64'hC3A5_0F1E_96D2_4B87;
  endfunction

  function automatic logic [31:0] mk_tok(int p, logic [2:0] code);
    logic [31:0] t = '1;
    t[p] = 1'b0;
    for (int j = 1; j <= 3; j++) if (p - j >= 0) t[p - j] = code[3 - j];
    return t;
  endfunction

  // status per R7: code under the highest zero, zero padded below bit 0
  function automatic logic [2:0] exp_stat(logic [31:0] t);
    int p = -1;
    logic [2:0] c = 3'b000;
    for (int i = 31; i >= 0; i--) if (p < 0 && !t[i]) p = i;
    if (p < 0) return 3'd3;
    if (p >= 1) c[2] = t[p - 1];
    if (p >= 2) c[1] = t[p - 2];
    if (p >= 3) c[0] = t[p - 3];
    case (c)
      3'b010:  return 3'd0;
      3'b101:  return 3'd1;
      3'b110:  return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  task automatic begin_xfer(int n);
    @(posedge clk); #1;
    start_i = 1'b1; blk_cnt_i = BLK_W'(n);
    @(negedge clk);
  endtask

  task automatic end_check(int exp_done, int exp_st);
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    chk("R8/R9 busy after end", busy_o, 0);
    chk("R8 lanes released", dat_oe_o, 0);
    chk("R8/R9 done count", done_cnt_o, exp_done);
    chk("R7/R9 status", status_o, exp_st);
  endtask

  task automatic run_block(int b, logic [31:0] tok, bit pulse_start);
    int k = 0;
    int guard = 0;
    @(posedge clk); #1;
    start_i = 1'b0; data_valid_i = 1'b0; crc_i = blk_crc(b);
    @(negedge clk);
    chk("R2 pre nibble", dat_o, 4'hF);
    chk("R2 pre oe", dat_oe_o, 1);
    chk("R4 pre clk en", bus_clk_en_o, 1);
    chk("R9 done before block", done_cnt_o, b);
    @(posedge clk); #1;
    crc_i = {$urandom, $urandom};
    if (pulse_start) begin start_i = 1'b1; blk_cnt_i = 1; end
    @(negedge clk);
    chk("R2 start nibble", dat_o, 4'h0);
    chk("R2 start oe", dat_oe_o, 1);
    while (k < NIB && guard < 20000) begin
      guard++;
      @(posedge clk); #1;
      start_i = 1'b0;
      data_i = pay_word(b, k / 8);
      data_valid_i = ($urandom % 6) != 0;
      @(negedge clk);
      chk("R3 ready at word boundary", data_ready_o, (k % 8) == 0);
      if (bus_clk_en_o) begin
        chk("R3 payload nibble", dat_o, pay_nib(b, k));
        k++;
      end else begin
        chk("R4 stall only when starved", {data_ready_o, data_valid_i}, 2'b10);
      end
    end
    chk("R3 payload length reached", k, NIB);
    for (int j = 0; j < 16; j++) begin
      @(posedge clk); #1; data_valid_i = 1'b0;
      @(negedge clk);
      chk("R5 crc nibble", dat_o, blk_crc(b) >> (60 - 4 * j) & 64'hF);
      chk("R5 crc oe", dat_oe_o, 1);
    end
    @(posedge clk); #1;
    @(negedge clk);
    chk("R5 end nibble", dat_o, 4'hF);
    chk("R5 end oe", dat_oe_o, 1);
    for (int j = 0; j < 32; j++) begin
      @(posedge clk); #1; dat0_i = tok[31 - j];
      @(negedge clk);
      chk("R6 token lanes released", dat_oe_o, 0);
      chk("R6 token clk en", bus_clk_en_o, 1);
    end
    @(posedge clk); #1; dat0_i = 1'b1;
    @(negedge clk);
    chk("R7 decode cycle busy", busy_o, 1);
    chk("R6 decode cycle oe", dat_oe_o, 0);
  endtask

  task automatic xfer(int n, int fail_at, logic [2:0] fail_code, bit pulse);
    logic [31:0] tok;
    logic [2:0] st;
    begin_xfer(n);
    for (int b = 0; b < n; b++) begin
      tok = mk_tok(3 + int'($urandom % 29), (b == fail_at) ? fail_code : 3'b010);
      run_block(b, tok, pulse && b == 0);
      st = exp_stat(tok);
      if (st != 3'd0) begin
        end_check(b, st);
        return;
      end
    end
    end_check(n, 0);
  endtask

  task automatic xfer_tok(logic [31:0] tok);
    logic [2:0] st = exp_stat(tok);
    begin_xfer(1);
    run_block(0, tok, 1'b0);
    end_check((st == 3'd0) ? 1 : 0, st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    salt = $urandom(32'h5D17);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 busy reset", busy_o, 0);
    chk("R1 oe reset", dat_oe_o, 0);
    chk("R1 ready reset", data_ready_o, 0);
    chk("R1 clk en reset", bus_clk_en_o, 0);
    chk("R1 done reset", done_cnt_o, 0);
    chk("R1 status reset", status_o, 0);

    // R11: second start mid-transfer asks for 1 block; must be ignored
    xfer(3, -1, 3'b010, 1'b1);
    xfer(2, 1, 3'b101, 1'b0);           // R7 crc error on second block
    xfer(1, 0, 3'b110, 1'b0);           // R7 write error
    xfer(1, 0, 3'b011, 1'b0);           // R7 unknown code
    xfer_tok(32'hFFFF_FFFF);            // R7 no start bit
    xfer_tok(mk_tok(1, 3'b100));        // R7 truncated code at bottom
    xfer_tok(mk_tok(3, 3'b010));        // R7 lowest full-code position, accepted
    xfer_tok(mk_tok(31, 3'b010));       // R7 start bit at very top
    for (int r = 0; r < 3; r++) xfer(1, 0, 3'($urandom % 8), 1'b0);

    // R10 timeout: stream starved forever
    begin_xfer(2);
    for (int c = 0; c <= TO; c++) begin
      @(posedge clk); #1; start_i = 1'b0; data_valid_i = 1'b0;
      @(negedge clk);
      if (c == TO - 1) chk("R10 busy before limit", busy_o, 1);
      if (c == TO) begin
        chk("R10 stopped at limit", busy_o, 0);
        chk("R10 timeout status", status_o, 4);
        chk("R10 lanes released", dat_oe_o, 0);
        chk("R10 done count", done_cnt_o, 0);
      end
    end

    // R11 zero-count start clears status and stays idle
    begin_xfer(0);
    end_check(0, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11 zero count stays idle", busy_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule